// File: doc/BRIEF.md
# Stack-Relative Floating-Point Register File

This block stores eight 80-bit registers arranged as a ring. Software normally names them by their distance from a moving top-of-stack pointer: slot 0 is the most recent push, slot 1 the entry pushed before it, and so on. A push lowers the pointer by one (wrapping) and fills the new top. A pop marks the top slot empty and raises the pointer by one. A read port and a write port both take a relative index. Each slot carries a valid tag. Pushing onto a valid slot signals overflow, and popping an empty slot signals underflow. The pointer moves in both cases.

The same storage also has a second view with fixed physical indices. It covers only the low 64 bits of each register and suits packed-integer work. This view ignores the pointer. Writing through it loads the low 64 bits and forces the top 16 bits to all ones, so such a register is easy to tell apart from a normal floating-point value. A value written through one view can be read through the other.

The two read ports are combinational and see the state as of the last clock edge. All updates take effect on the rising clock edge.

Top module: `fpstk_regfile`

## Requirements
- R1: After reset, top_o is 0, every slot is tagged empty, every register holds zero, empty_o is 1, and full_o, ovf_o and unf_o are 0.
- R2: A push sets top_o to (top_o - 1) mod 8 and writes push_data_i to that physical slot, marking it valid. One cycle later the new value reads at relative index 0, and the value that was at relative index i reads at index i+1.
- R3: A pop without a push sets top_o to (top_o + 1) mod 8 and marks the old top slot empty. In the pop cycle, relative index 0 still returns the popped value.
- R4: rd_data_o is the register at physical slot (top_o + rd_idx_i) mod 8, and rd_valid_o is that slot's tag. Both are combinational.
- R5: A stack-view write lands at physical slot (P + wr_idx_i) mod 8 and marks it valid. P is the pointer value after any push or pop in the same cycle.
- R6: mm_rd_data_o is bits [63:0] of physical slot mm_rd_idx_i, whatever the value of top_o. Values written through the stack view are visible there.
- R7: An alias write sets bits [63:0] of physical slot mm_wr_idx_i to mm_wr_data_i and bits [79:64] to 16'hFFFF, and marks the slot valid. The result is visible through the stack view.
- R8: A push whose target slot is already valid drives ovf_o high for exactly the following cycle. The pointer still moves and the slot is overwritten.
- R9: A pop whose top slot is empty drives unf_o high for exactly the following cycle. The pointer still moves.
- R10: empty_o is 1 exactly when no slot is valid, and full_o is 1 exactly when all eight slots are valid.
- R11: When push_i and pop_i are both high, the pop is ignored. The cycle acts as a plain push and never raises unf_o.
- R12: When writes in one cycle hit the same physical slot, the stack-view write wins over the push, and the push wins over the alias write. In that cycle a write that lands on the popped slot leaves it valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push push_data_i onto the stack |
| push_data_i | input | 80 | Data for a push |
| pop_i | input | 1 | Pop the top entry |
| rd_idx_i | input | 3 | Relative index for the stack-view read |
| rd_data_o | output | 80 | Register at the relative read index |
| rd_valid_o | output | 1 | Tag of the slot being read |
| wr_en_i | input | 1 | Stack-view write enable |
| wr_idx_i | input | 3 | Relative index for the write, applied after this cycle's push or pop |
| wr_data_i | input | 80 | Stack-view write data |
| mm_rd_idx_i | input | 3 | Physical index for the 64-bit read |
| mm_rd_data_o | output | 64 | Low 64 bits of that physical register |
| mm_wr_en_i | input | 1 | 64-bit alias write enable |
| mm_wr_idx_i | input | 3 | Physical index for the alias write |
| mm_wr_data_i | input | 64 | Alias write data |
| top_o | output | 3 | Current top-of-stack pointer |
| empty_o | output | 1 | No slot valid |
| full_o | output | 1 | All slots valid |
| ovf_o | output | 1 | One-cycle pulse after a push onto a valid slot |
| unf_o | output | 1 | One-cycle pulse after a pop of an empty slot |

## Verification
The hardest cases to reach are the ones where one clock edge carries several updates to the same physical slot: a push together with a relative write, a push together with an alias write, or a pop together with a write that lands on the slot being freed. Only at such an edge do the "after the push" addressing rule and the write priority show.

The bench reaches these cases on purpose. It first walks the pointer to a known value. It then computes which physical slot the push will take and points the alias write at it. It also uses relative index 7 during a pop, which lands exactly on the freed slot. Overflow and underflow are reached by filling or draining all eight slots and then doing one more operation. This also wraps the pointer through zero.

// File: rtl/fpstk_pkg.sv
// Package: fpstk_pkg
// Shared size constants for the stack-relative register file.
// Assumes NSLOT is a power of two so pointer arithmetic wraps by truncation.
package fpstk_pkg;
    localparam int unsigned FP_W  = 80;
    localparam int unsigned MM_W  = 64;
    localparam int unsigned NSLOT = 8;
endpackage

// File: rtl/fpstk_ctrl.sv
// Module: fpstk_ctrl
// Holds the top-of-stack pointer and computes its next value.
// Registers the overflow and underflow pulses.
// Assumes push takes precedence over pop, and that tags_i shows the stored tags before this edge.
module fpstk_ctrl #(
    parameter int unsigned NSLOT = 8,
    localparam int unsigned IDXW = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [NSLOT-1:0] tags_i,
    output logic [IDXW-1:0]  top_q,
    output logic [IDXW-1:0]  top_nxt,
    output logic             pop_eff,
    output logic             ovf_q,
    output logic             unf_q
);
    logic [IDXW-1:0] below;
    logic [IDXW-1:0] above;

    // Neighbouring pointer values, wrapping modulo NSLOT
    always_comb begin
        below = top_q - 1'b1;
        above = top_q + 1'b1;
    end

    // Choose the next pointer: push wins, and a pop on its own moves the pointer up
    always_comb begin
        pop_eff = pop_i & ~push_i;
        if (push_i)       top_nxt = below;
        else if (pop_eff) top_nxt = above;
        else              top_nxt = top_q;
    end

    // Pointer register
    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_nxt;
    end

    // One-cycle pulses for a push onto a valid slot and a pop of an empty slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= push_i & tags_i[below];
            unf_q <= pop_eff & ~tags_i[top_q];
        end
    end
endmodule

// File: rtl/fpstk_store.sv
// Module: fpstk_store
// Register array with one valid tag per slot.
// Each slot picks its own write source by fixed priority: stack write, then push, then alias write.
// Assumes the physical indices have already been computed by the parent.
module fpstk_store #(
    parameter int unsigned NSLOT = 8,
    parameter int unsigned FP_W  = 80,
    parameter int unsigned MM_W  = 64,
    localparam int unsigned IDXW = $clog2(NSLOT),
    localparam int unsigned EXTW = FP_W - MM_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [IDXW-1:0]            push_phys,
    input  logic [FP_W-1:0]            push_data,
    input  logic                       pop_eff,
    input  logic [IDXW-1:0]            pop_phys,
    input  logic                       sw_en,
    input  logic [IDXW-1:0]            sw_phys,
    input  logic [FP_W-1:0]            sw_data,
    input  logic                       mw_en,
    input  logic [IDXW-1:0]            mw_idx,
    input  logic [MM_W-1:0]            mw_data,
    output logic [NSLOT-1:0][FP_W-1:0] slots_q,
    output logic [NSLOT-1:0]           tags_q
);
    // Alias data widened to a full register, with the upper bits forced to ones
    logic [FP_W-1:0] mw_full;
    always_comb mw_full = {{EXTW{1'b1}}, mw_data};

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        logic sw_hit, push_hit, mw_hit, pop_hit;
        logic [FP_W-1:0] d_nxt;
        logic            t_nxt;

        // Decide which writers target this slot and pick the winner
        always_comb begin
            sw_hit   = sw_en   && (sw_phys   == IDXW'(s));
            push_hit = push_i  && (push_phys == IDXW'(s));
            mw_hit   = mw_en   && (mw_idx    == IDXW'(s));
            pop_hit  = pop_eff && (pop_phys  == IDXW'(s));
            if (sw_hit)        d_nxt = sw_data;
            else if (push_hit) d_nxt = push_data;
            else if (mw_hit)   d_nxt = mw_full;
            else               d_nxt = slots_q[s];
            if (sw_hit | push_hit | mw_hit) t_nxt = 1'b1;
            else if (pop_hit)               t_nxt = 1'b0;
            else                            t_nxt = tags_q[s];
        end

        // Slot data and tag registers
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots_q[s] <= '0;
                tags_q[s]  <= 1'b0;
            end else begin
                slots_q[s] <= d_nxt;
                tags_q[s]  <= t_nxt;
            end
        end
    end
endmodule

// File: rtl/fpstk_view.sv
// Module: fpstk_view
// Combinational read paths: a stack-relative full-width read and a fixed-index low-part read.
// Also derives the empty and full status from the tags.
// Assumes the pointer and storage are registered upstream.
module fpstk_view #(
    parameter int unsigned NSLOT = 8,
    parameter int unsigned FP_W  = 80,
    parameter int unsigned MM_W  = 64,
    localparam int unsigned IDXW = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0][FP_W-1:0] slots_i,
    input  logic [NSLOT-1:0]           tags_i,
    input  logic [IDXW-1:0]            top_i,
    input  logic [IDXW-1:0]            rd_idx,
    input  logic [IDXW-1:0]            mm_idx,
    output logic [FP_W-1:0]            rd_data,
    output logic                       rd_valid,
    output logic [MM_W-1:0]            mm_data,
    output logic                       empty,
    output logic                       full
);
    logic [IDXW-1:0] rd_phys;

    // Relative read, translated through the pointer
    always_comb begin
        rd_phys  = top_i + rd_idx;
        rd_data  = slots_i[rd_phys];
        rd_valid = tags_i[rd_phys];
    end

    // Fixed-index read of the low part
    always_comb mm_data = slots_i[mm_idx][MM_W-1:0];

    // Occupancy status
    always_comb begin
        empty = ~|tags_i;
        full  = &tags_i;
    end
endmodule

// File: rtl/fpstk_regfile.sv
// Module: fpstk_regfile
// Eight-entry register file, addressed relative to a top-of-stack pointer, with a fixed-index 64-bit alias view.
// Assumes NSLOT is a power of two. A relative write uses the pointer value after this cycle's push or pop.
module fpstk_regfile #(
    parameter int unsigned NSLOT = fpstk_pkg::NSLOT,
    parameter int unsigned FP_W  = fpstk_pkg::FP_W,
    parameter int unsigned MM_W  = fpstk_pkg::MM_W,
    localparam int unsigned IDXW = $clog2(NSLOT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic [FP_W-1:0] push_data_i,
    input  logic            pop_i,
    input  logic [IDXW-1:0] rd_idx_i,
    output logic [FP_W-1:0] rd_data_o,
    output logic            rd_valid_o,
    input  logic            wr_en_i,
    input  logic [IDXW-1:0] wr_idx_i,
    input  logic [FP_W-1:0] wr_data_i,
    input  logic [IDXW-1:0] mm_rd_idx_i,
    output logic [MM_W-1:0] mm_rd_data_o,
    input  logic            mm_wr_en_i,
    input  logic [IDXW-1:0] mm_wr_idx_i,
    input  logic [MM_W-1:0] mm_wr_data_i,
    output logic [IDXW-1:0] top_o,
    output logic            empty_o,
    output logic            full_o,
    output logic            ovf_o,
    output logic            unf_o
);
    logic [IDXW-1:0]            top_q, top_nxt, sw_phys;
    logic                       pop_eff;
    logic [NSLOT-1:0][FP_W-1:0] slots_q;
    logic [NSLOT-1:0]           tags_q;

    // Place the relative write against the post-update pointer
    always_comb sw_phys = top_nxt + wr_idx_i;

    fpstk_ctrl #(.NSLOT(NSLOT)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .tags_i  (tags_q),
        .top_q   (top_q),
        .top_nxt (top_nxt),
        .pop_eff (pop_eff),
        .ovf_q   (ovf_o),
        .unf_q   (unf_o)
    );

    fpstk_store #(.NSLOT(NSLOT), .FP_W(FP_W), .MM_W(MM_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .push_phys (top_nxt),
        .push_data (push_data_i),
        .pop_eff   (pop_eff),
        .pop_phys  (top_q),
        .sw_en     (wr_en_i),
        .sw_phys   (sw_phys),
        .sw_data   (wr_data_i),
        .mw_en     (mm_wr_en_i),
        .mw_idx    (mm_wr_idx_i),
        .mw_data   (mm_wr_data_i),
        .slots_q   (slots_q),
        .tags_q    (tags_q)
    );

    fpstk_view #(.NSLOT(NSLOT), .FP_W(FP_W), .MM_W(MM_W)) u_view (
        .slots_i  (slots_q),
        .tags_i   (tags_q),
        .top_i    (top_q),
        .rd_idx   (rd_idx_i),
        .mm_idx   (mm_rd_idx_i),
        .rd_data  (rd_data_o),
        .rd_valid (rd_valid_o),
        .mm_data  (mm_rd_data_o),
        .empty    (empty_o),
        .full     (full_o)
    );

    // Bring out the pointer
    always_comb top_o = top_q;
endmodule

// File: rtl/fpstk_checker.sv
// Module: fpstk_checker
// Temporal properties of fpstk_regfile.
// Attached to every instance by the bind statement at the end of this file.
module fpstk_checker #(
    parameter int unsigned NSLOT = 8,
    parameter int unsigned FP_W  = 80,
    parameter int unsigned MM_W  = 64,
    localparam int unsigned IDXW = $clog2(NSLOT)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       push_i,
    input logic [FP_W-1:0]            push_data_i,
    input logic                       pop_i,
    input logic                       wr_en_i,
    input logic                       mm_wr_en_i,
    input logic [IDXW-1:0]            mm_wr_idx_i,
    input logic [IDXW-1:0]            top_o,
    input logic                       empty_o,
    input logic                       full_o,
    input logic                       ovf_o,
    input logic                       unf_o,
    input logic [NSLOT-1:0][FP_W-1:0] slots_q,
    input logic [NSLOT-1:0]           tags_q
);
    logic [IDXW-1:0] below, above;

    // Pointer neighbours, used to predict the next value
    always_comb begin
        below = top_o - 1'b1;
        above = top_o + 1'b1;
    end

    a_r2_push_moves_top: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> top_o == $past(below));
    a_r2_push_data_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && !wr_en_i |=> slots_q[top_o] == $past(push_data_i) && tags_q[top_o]);
    a_r3_pop_moves_top: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !push_i |=> top_o == $past(above));
    a_r3_pop_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !push_i && !wr_en_i && !mm_wr_en_i |=> !tags_q[$past(top_o)]);
    a_r7_alias_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
        mm_wr_en_i && !push_i && !wr_en_i |=> &slots_q[$past(mm_wr_idx_i)][FP_W-1:MM_W]);
    a_r8_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && tags_q[below] |=> ovf_o);
    a_r8_no_spurious_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !push_i |=> !ovf_o);
    a_r9_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !push_i && !tags_q[top_o] |=> unf_o);
    a_r10_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));
    a_r11_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && pop_i |=> !unf_o);
endmodule

bind fpstk_regfile fpstk_checker #(.NSLOT(NSLOT), .FP_W(FP_W), .MM_W(MM_W)) u_fpstk_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .pop_i       (pop_i),
    .wr_en_i     (wr_en_i),
    .mm_wr_en_i  (mm_wr_en_i),
    .mm_wr_idx_i (mm_wr_idx_i),
    .top_o       (top_o),
    .empty_o     (empty_o),
    .full_o      (full_o),
    .ovf_o       (ovf_o),
    .unf_o       (unf_o),
    .slots_q     (slots_q),
    .tags_q      (tags_q)
);

// File: tb/fpstk_regfile_bench.sv
`timescale 1ns/1ps
// Directed bench for fpstk_regfile.
// A small reference model follows the written requirements.
// After each operation, a check sweeps both read views against that model.
module fpstk_regfile_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 0, pop_i = 0, wr_en_i = 0, mm_wr_en_i = 0;
    logic [79:0] push_data_i = '0, wr_data_i = '0, rd_data_o;
    logic [2:0]  rd_idx_i = '0, wr_idx_i = '0, mm_rd_idx_i = '0, mm_wr_idx_i = '0, top_o;
    logic [63:0] mm_wr_data_i = '0, mm_rd_data_o;
    logic        rd_valid_o, empty_o, full_o, ovf_o, unf_o;

    int checks = 0;
    int errors = 0;

    logic [79:0] m_reg [8];
    logic [7:0]  m_tag;
    logic [2:0]  m_top;
    logic        m_ovf, m_unf;

    always #5 clk = ~clk;

    fpstk_regfile u_fpstk_regfile (.*);

    // Compare one value; report on a mismatch
    task automatic chk(string req, string what, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Check status and both read views for every index against the model
    task automatic chk_all(string req);
        chk(req, "top", 80'(top_o), 80'(m_top));
        chk(req, "empty", 80'(empty_o), 80'(m_tag == 8'h00));
        chk(req, "full", 80'(full_o), 80'(m_tag == 8'hFF));
        chk(req, "ovf", 80'(ovf_o), 80'(m_ovf));
        chk(req, "unf", 80'(unf_o), 80'(m_unf));
        for (int i = 0; i < 8; i++) begin
            logic [2:0] ph;
            ph = m_top + 3'(i);
            rd_idx_i = 3'(i);
            mm_rd_idx_i = 3'(i);
            #1;
            chk(req, $sformatf("st%0d data", i), rd_data_o, m_reg[ph]);
            chk(req, $sformatf("st%0d tag", i), 80'(rd_valid_o), 80'(m_tag[ph]));
            chk(req, $sformatf("mm%0d data", i), 80'(mm_rd_data_o), 80'(m_reg[i][63:0]));
        end
    endtask

    // Apply one cycle of stimulus, then update the model by the requirement rules
    task automatic step(logic psh, logic [79:0] pd, logic pp,
                        logic we, logic [2:0] wi, logic [79:0] wd,
                        logic me, logic [2:0] mi, logic [63:0] md);
        logic [2:0] nt;
        push_i = psh; push_data_i = pd; pop_i = pp;
        wr_en_i = we; wr_idx_i = wi; wr_data_i = wd;
        mm_wr_en_i = me; mm_wr_idx_i = mi; mm_wr_data_i = md;
        @(posedge clk);
        #1;
        push_i = 0; pop_i = 0; wr_en_i = 0; mm_wr_en_i = 0;
        m_ovf = 0; m_unf = 0;
        if (psh) begin nt = m_top - 3'd1; m_ovf = m_tag[nt]; end
        else if (pp) begin nt = m_top + 3'd1; m_unf = !m_tag[m_top]; m_tag[m_top] = 0; end
        else nt = m_top;
        if (me)  begin m_reg[mi] = {16'hFFFF, md}; m_tag[mi] = 1; end
        if (psh) begin m_reg[nt] = pd; m_tag[nt] = 1; end
        if (we)  begin m_reg[3'(nt + wi)] = wd; m_tag[3'(nt + wi)] = 1; end
        m_top = nt;
        @(negedge clk);
    endtask

    task automatic do_push(logic [79:0] d);
        step(1, d, 0, 0, 0, '0, 0, 0, '0);
    endtask
    task automatic do_pop();
        step(0, '0, 1, 0, 0, '0, 0, 0, '0);
    endtask

    task automatic t_reset();
        chk_all("R1");
        chk_all("R10");
    endtask

    task automatic t_push_pop();
        do_push(80'hA1A1_0000_0000_0000_0001);
        chk_all("R2");
        do_push(80'hB2B2_0000_0000_0000_0002);
        do_push(80'hC3C3_0000_0000_0000_0003);
        chk_all("R4");
        rd_idx_i = 0; pop_i = 1; #1;
        chk("R3", "read in pop cycle", rd_data_o, 80'hC3C3_0000_0000_0000_0003);
        pop_i = 0;
        do_pop();
        chk_all("R3");
    endtask

    task automatic t_rel_write();
        step(0, '0, 0, 1, 1, 80'h1111_2222_3333_4444_5555, 0, 0, '0);
        chk_all("R5");
        step(1, 80'hDEAD_0000_0000_0000_0000, 0, 1, 0, 80'hBEEF_0000_0000_0000_0001, 0, 0, '0);
        chk_all("R12");
        step(1, 80'h7777_0000_0000_0000_0007, 0, 1, 1, 80'h8888_0000_0000_0000_0008, 0, 0, '0);
        chk_all("R5");
        step(0, '0, 1, 1, 7, 80'h9999_0000_0000_0000_0009, 0, 0, '0);
        chk_all("R12");
    endtask

    task automatic t_alias();
        step(0, '0, 0, 0, 0, '0, 1, 3'd5, 64'h0123_4567_89AB_CDEF);
        chk_all("R7");
        step(0, '0, 0, 1, 2, 80'hCAFE_F00D_1234_5678_9ABC, 0, 0, '0);
        chk_all("R6");
        step(1, 80'h4242_0000_0000_0000_0042, 0, 0, 0, '0, 1, 3'(m_top - 3'd1), 64'hFFFF_0000_FFFF_0000);
        chk_all("R12");
    endtask

    task automatic t_overflow();
        while (m_tag != 8'hFF) do_push({16'h5A5A, 56'h0, 5'h0, m_top});
        chk_all("R10");
        do_push(80'hEEEE_EEEE_EEEE_EEEE_EEEE);
        chk_all("R8");
        @(negedge clk); m_ovf = 0;
        chk_all("R8");
    endtask

    task automatic t_underflow();
        while (m_tag != 8'h00) do_pop();
        chk_all("R10");
        do_pop();
        chk_all("R9");
    endtask

    task automatic t_push_pop_same();
        step(1, 80'h3C3C_0000_0000_0000_003C, 1, 0, 0, '0, 0, 0, '0);
        chk_all("R11");
        step(1, 80'h4D4D_0000_0000_0000_004D, 1, 0, 0, '0, 0, 0, '0);
        chk_all("R11");
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_tag = '0; m_top = '0; m_ovf = 0; m_unf = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        t_reset();
        t_push_pop();
        t_rel_write();
        t_alias();
        t_underflow();
        t_push_pop_same();
        t_overflow();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule